// File: doc/BRIEF.md
# System-Management Memory Window Control and Router

This block holds the 8-bit control byte for the system-management memory window. For every memory cycle that falls inside that window, it decides whether the cycle is served by DRAM or passed on to PCI. Software programs the byte through a write strobe and data bus. The current value reads back on a parallel output.

Each write is cleaned before it is stored. Only the open, closed, lock and enable bits come from the data. The top bit is held at zero, and the segment field is held at a fixed base code.

Once the lock bit has been stored, it can only be cleared by reset. Every later write while locked keeps lock set and clears the open bit.

The routing decision is combinational. It depends on the stored byte and on three per-access inputs:
- whether the CPU is in system-management mode,
- whether the access is an instruction fetch or a data reference,
- whether the address hits the window.

A registered flag reports the illegal setting in which the open and closed bits are both set.

Top module: `smram_gate`

## Requirements
- R1: After reset the control readback is 0x02, the illegal-setting flag is 0, and `to_dram` is 0 for every access.
- R2: A write stores data bits 6:3 into readback bits 6:3, forces bit 7 to 0, and forces bits 2:0 to the base segment code `3'b010`. The bit meanings are: bit 6 open, bit 5 closed, bit 4 lock, bit 3 enable.
- R3: When the stored lock bit (bit 4) is 1, a write stores lock as 1 and open (bit 6) as 0, whatever the data. Only reset clears lock.
- R4: Without a write strobe the stored byte holds its value.
- R5: With enable (bit 3) at 0, every access goes to PCI (`to_dram`=0).
- R6: Enabled, unlocked, open=0, closed=0: an access goes to DRAM (`to_dram`=1) exactly when `in_smm`=1.
- R7: Enabled, unlocked, open=1, closed=0: code and data both go to DRAM, whatever `in_smm` is.
- R8: Enabled with closed=1 and `in_smm`=1, and either open=0 or lock=1: an instruction fetch (`is_code`=1) goes to DRAM and a data reference (`is_code`=0) goes to PCI.
- R9: Enabled and locked with `in_smm`=0: every access goes to PCI.
- R10: The illegal-setting flag `cfg_err` equals open AND closed of the stored byte and updates in the same cycle as the byte. While that setting is stored and unlocked, every access goes to PCI.
- R11: With `seg_hit`=0, `to_dram` is 0.
- R12: Enabled and locked with closed=0 and `in_smm`=1: code and data both go to DRAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data for the control byte |
| in_smm | input | 1 | CPU is in system-management mode for this access |
| is_code | input | 1 | 1 = instruction fetch, 0 = data reference |
| seg_hit | input | 1 | Access address falls inside the window |
| ctrl_q | output | 8 | Stored control byte readback |
| to_dram | output | 1 | 1 = route to DRAM, 0 = route to PCI |
| cfg_err | output | 1 | Stored byte has both open and closed set |

## Verification
The bench builds the block with its default base segment code `3'b010`. The stored state then reduces to four live bits. This makes it practical to apply every ordered pair of two writes from reset: 256 pairs, covering every transition into and out of the locked state.

After each pair, all eight combinations of mode, access kind and window hit are applied. The route is compared against a truth table written row by row in the bench.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int unsigned CTRL_W = 8;

  typedef struct packed {
    logic       rsvd;
    logic       open;
    logic       closed;
    logic       lock;
    logic       enable;
    logic [2:0] seg;
  } smram_ctrl_t;

  // Clean a write: keep the four control bits, force the rest,
  // and apply the lock rule of the stored value.
  function automatic smram_ctrl_t sanitize_write(
    input smram_ctrl_t      cur,
    input logic [CTRL_W-1:0] data,
    input logic [2:0]       base_seg
  );
    smram_ctrl_t nx;
    nx.rsvd   = 1'b0;
    nx.open   = data[6];
    nx.closed = data[5];
    nx.lock   = data[4];
    nx.enable = data[3];
    nx.seg    = base_seg;
    if (cur.lock) begin
      nx.lock = 1'b1;
      nx.open = 1'b0;
    end
    return nx;
  endfunction

  // Route decision: 1 means DRAM, 0 means PCI.
  function automatic logic route_to_dram(
    input logic enable,
    input logic lock,
    input logic closed,
    input logic open,
    input logic smm,
    input logic code
  );
    logic conflict;
    logic open_path;
    logic smm_path;
    conflict  = open & closed & ~lock;
    open_path = open & ~lock;
    smm_path  = smm & (code | ~closed);
    return enable & ~conflict & (open_path | smm_path);
  endfunction

endpackage

// File: rtl/smram_reg.sv
module smram_reg
  import smram_pkg::*;
#(
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output smram_ctrl_t       ctrl_q,
  output logic              err_q
);

  localparam smram_ctrl_t RESET_VAL = '{rsvd: 1'b0, open: 1'b0, closed: 1'b0,
                                        lock: 1'b0, enable: 1'b0, seg: BASE_SEG};

  smram_ctrl_t ctrl_next;
  logic        lock_hold;

  assign lock_hold = ctrl_q.lock;
  assign ctrl_next = sanitize_write(ctrl_q, wr_data, BASE_SEG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= RESET_VAL;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_next;
      err_q  <= ctrl_next.open & ctrl_next.closed;
    end
  end

  // R3: lock stays set until reset
  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hold |=> ctrl_q.lock);

  // R3: a write while locked leaves open cleared
  assert_locked_write_clears_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_hold) |=> !ctrl_q.open);

  // R2: forced fields after a write
  assert_forced_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q.seg == BASE_SEG && !ctrl_q.rsvd));

  // R4: no write, no change
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(err_q)));

  // R10: flag follows stored open and closed
  assert_err_matches_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (err_q == (ctrl_q.open & ctrl_q.closed)));

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic enable,
  input  logic lock,
  input  logic closed,
  input  logic open,
  input  logic in_smm,
  input  logic is_code,
  input  logic seg_hit,
  output logic to_dram
);

  logic route_raw;

  assign route_raw = route_to_dram(enable, lock, closed, open, in_smm, is_code);
  assign to_dram   = seg_hit & route_raw;

endmodule

// File: rtl/smram_gate.sv
module smram_gate
  import smram_pkg::*;
#(
  parameter logic [2:0] BASE_SEG = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              in_smm,
  input  logic              is_code,
  input  logic              seg_hit,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              to_dram,
  output logic              cfg_err
);

  smram_ctrl_t ctrl_s;
  logic        err_s;

  smram_reg #(.BASE_SEG(BASE_SEG)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_s),
    .err_q   (err_s)
  );

  smram_route u_route (
    .enable  (ctrl_s.enable),
    .lock    (ctrl_s.lock),
    .closed  (ctrl_s.closed),
    .open    (ctrl_s.open),
    .in_smm  (in_smm),
    .is_code (is_code),
    .seg_hit (seg_hit),
    .to_dram (to_dram)
  );

  assign ctrl_q  = ctrl_s;
  assign cfg_err = err_s;

  // R5: disabled window never reaches DRAM
  assert_disabled_to_pci_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_s.enable |-> !to_dram);

  // R11: no window hit, no DRAM
  assert_miss_to_pci_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_hit |-> !to_dram);

  // R9: locked and outside the mode goes to PCI
  assert_locked_outside_pci_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s.lock && !in_smm) |-> !to_dram);

  // R8: closed data reference in mode goes to PCI
  assert_closed_data_pci_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s.closed && in_smm && !is_code && (!ctrl_s.open || ctrl_s.lock)) |-> !to_dram);

  // R10: illegal unlocked setting routes to PCI
  assert_conflict_pci_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !ctrl_s.lock) |-> !to_dram);

endmodule

// File: tb/sim_smram_gate.sv
module sim_smram_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       in_smm, is_code, seg_hit;
  logic [7:0] ctrl_q;
  logic       to_dram, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  smram_gate u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .in_smm(in_smm), .is_code(is_code), .seg_hit(seg_hit),
    .ctrl_q(ctrl_q), .to_dram(to_dram), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Bench truth table, row by row.
  function automatic logic model_route(input logic [7:0] c, input logic smm,
                                       input logic code, input logic hit);
    logic op, cl, lk, en;
    op = c[6]; cl = c[5]; lk = c[4]; en = c[3];
    if (!hit) return 1'b0;                        // R11
    if (!en) return 1'b0;                         // R5
    if (lk) begin
      if (!smm) return 1'b0;                      // R9
      if (cl) return code;                        // R8
      return 1'b1;                                // R12
    end
    if (op && cl) return 1'b0;                    // R10
    if (op) return 1'b1;                          // R7
    if (!smm) return 1'b0;                        // R6
    if (cl) return code;                          // R8
    return 1'b1;                                  // R6
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'hA5;
  endtask

  task automatic sweep_route(input logic [7:0] exp_c, input string tag);
    for (int k = 0; k < 8; k++) begin
      in_smm = k[0]; is_code = k[1]; seg_hit = k[2];
      #1;
      check(tag, {7'd0, to_dram}, {7'd0, model_route(exp_c, k[0], k[1], k[2])});
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    in_smm = 1'b0; is_code = 1'b0; seg_hit = 1'b1;
    do_reset();
    // R1 reset state
    check("R1 ctrl", ctrl_q, 8'h02);
    check("R1 err", {7'd0, cfg_err}, 8'h00);
    sweep_route(8'h02, "R1 route");

    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] ea, eb, da, db;
        da = {1'b1, a[3:0], 3'b101};  // junk in forced bits
        db = {1'b1, b[3:0], 3'b111};
        do_reset();
        do_write(da);
        ea = {1'b0, a[3:0], 3'b010};
        check("R2 first write", ctrl_q, ea);
        check("R10 err first", {7'd0, cfg_err}, {7'd0, ea[6] & ea[5]});
        // R4: idle cycles keep the value
        @(negedge clk);
        check("R4 hold", ctrl_q, ea);
        do_write(db);
        eb = {1'b0, b[3:0], 3'b010};
        if (ea[4]) begin
          eb[4] = 1'b1;
          eb[6] = 1'b0;
        end
        check("R3 second write", ctrl_q, eb);
        check("R10 err second", {7'd0, cfg_err}, {7'd0, eb[6] & eb[5]});
        sweep_route(eb, "R5-R12 route");
      end
    end

    // R3: only reset clears the lock
    do_reset();
    do_write(8'h50);
    check("R3 lock set with open", ctrl_q, 8'h52);
    do_write(8'h48);
    check("R3 lock kept open cleared", ctrl_q, 8'h1A);
    do_reset();
    check("R3 reset clears lock", ctrl_q, 8'h02);
    do_write(8'h48);
    check("R7 open after unlock", ctrl_q, 8'h4A);
    in_smm = 1'b0; is_code = 1'b0; seg_hit = 1'b1; #1;
    check("R7 data outside mode to DRAM", {7'd0, to_dram}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule